// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block sits beside the register file of a 16550-style serial port and turns five interrupt conditions into one prioritised identification byte and one interrupt request to the processor. Each condition arrives as a one-cycle event pulse. If its enable bit is set, the pulse latches a pending flag for that source. The flag stays set until the register access that belongs to that source acknowledges it.

The identification byte reports one source at a time: the highest-priority pending source that is also enabled. Its bit 0 is an active-low "interrupt pending" flag. When the reported source is acknowledged and another source is still pending, the request stays high and the byte moves on to the next source. Software can therefore service a source, read the byte again and keep going until bit 0 returns to 1.

The upper two bits reflect whether the FIFOs are switched on. The surrounding register file, the FIFOs and the serial engines stay outside this block. They supply the event pulses, the enable mask and the access strobes.

Top module: `uart_int_ident`

## Requirements
- R1: After reset, `id_o` reads 8'h01 and `irq_o` is 0.
- R2: `id_o[0]` is 0 exactly when at least one pending source is enabled, and `irq_o` is 1 exactly when `id_o[0]` is 0.
- R3: Only the highest-priority enabled pending source is reported in `id_o[3:0]`. Sources are indexed by `src_evt_i`/`src_ack_i` bit, and the priority order from highest to lowest is bit 0 line status (0110), bit 1 received data (0100), bit 2 character timeout (1100), bit 3 transmit holding empty (0010), bit 4 modem status (0000).
- R4: `id_o[3]` is 1 only while the character-timeout source (bit 2) is the one reported.
- R5: An event is latched only if its source is enabled in `en_i` at that edge. Clearing an enable bit hides an already-pending source without discarding it. `en_i` maps as bit 0 → line status, bit 1 → received data and timeout, bit 2 → transmit empty, bit 3 → modem status.
- R6: A `src_ack_i` pulse clears only its own source. If other sources remain pending, the next one becomes the reported source.
- R7: A pulse on `id_rd_i` clears the transmit-empty source when that source is the one being reported. It has no effect on that source while another source is reported.
- R8: `id_o[7:6]` is 2'b11 when `fifo_en_i` is 1 and 2'b00 otherwise. `id_o[5:4]` is always 2'b00.
- R9: If an event and an acknowledge hit the same source on the same edge, the source stays pending.
- R10: The single received-data enable bit (`en_i[1]`) enables both the received-data and the character-timeout sources.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt_i | input | 5 | One-cycle event pulse per source (index as in R3) |
| src_ack_i | input | 5 | Access strobe that acknowledges each source |
| en_i | input | 4 | Interrupt enable mask (map in R5) |
| fifo_en_i | input | 1 | FIFOs enabled |
| id_rd_i | input | 1 | Identification byte is being read this cycle |
| id_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench sweeps every combination of the five pending flags against all 16 enable masks, with the FIFOs both on and off. A design with a wrong priority or a swapped code would report the wrong cause. A design that does not gate by the shared received-data enable would leak the timeout source. The bench then walks a full service sequence, acknowledging one source at a time. It also checks that an identification read leaves the transmit-empty flag alone while a higher source is shown: a design that cleared it anyway would lose that interrupt. A same-edge event and acknowledge must leave the source pending, where a clear-wins design would silently drop a fresh event. An event that arrives while its source is disabled must never be reported later.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

   localparam int N_SRC = 5;
   localparam int EN_W  = 4;
   localparam int ID_W  = 8;

   typedef enum logic [2:0] {
      SRC_LINE = 3'd0,
      SRC_RXD  = 3'd1,
      SRC_TOUT = 3'd2,
      SRC_TXE  = 3'd3,
      SRC_MDM  = 3'd4
   } src_e;

   // Cause code placed in identification bits 3..0 for a given source.
   function automatic logic [3:0] cause_code(input int idx, input bit tout_own);
      case (idx)
         0:       cause_code = 4'b0110;
         1:       cause_code = 4'b0100;
         2:       cause_code = tout_own ? 4'b1100 : 4'b0100;
         3:       cause_code = 4'b0010;
         default: cause_code = 4'b0000;
      endcase
   endfunction

endpackage

// File: rtl/uart_iid_pend.sv
module uart_iid_pend #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);

   for (genvar g = 0; g < N; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        pend_o[g] <= 1'b0;
         else if (set_i[g]) pend_o[g] <= 1'b1;
         else if (clr_i[g]) pend_o[g] <= 1'b0;
      end

      p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[g] |=> pend_o[g]);

      p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[g] && !set_i[g]) |=> !pend_o[g]);
   end

endmodule

// File: rtl/uart_iid_prio.sv
module uart_iid_prio #(
   parameter int N = 5
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] grant_o,
   output logic         any_o
);

   for (genvar g = 0; g < N; g++) begin : g_chain
      if (g == 0) begin : g_top
         assign grant_o[g] = req_i[g];
      end else begin : g_low
         assign grant_o[g] = req_i[g] & ~(|req_i[g-1:0]);
      end
   end

   assign any_o = |req_i;

   always_comb begin
      p_one_grant_r3: assert ($onehot0(grant_o));
      p_grant_req_r5: assert ((grant_o & ~req_i) == '0);
   end

endmodule

// File: rtl/uart_iid_encode.sv
module uart_iid_encode
   import uart_iid_pkg::*;
#(
   parameter int N        = 5,
   parameter bit TOUT_OWN = 1'b1
) (
   input  logic [N-1:0] grant_i,
   input  logic         any_i,
   input  logic         fifo_en_i,
   output logic [7:0]   id_o
);

   logic [3:0] cause;

   always_comb begin
      cause = '0;
      for (int k = 0; k < N; k++) begin
         if (grant_i[k]) cause |= cause_code(k, TOUT_OWN);
      end
   end

   assign id_o = {{2{fifo_en_i}}, 2'b00, cause[3:1], ~any_i};

endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
   import uart_iid_pkg::*;
#(
   parameter int N_SRCS  = N_SRC,
   parameter int EN_BITS = EN_W,
   parameter bit TOUT_ID = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_SRCS-1:0]  src_evt_i,
   input  logic [N_SRCS-1:0]  src_ack_i,
   input  logic [EN_BITS-1:0] en_i,
   input  logic               fifo_en_i,
   input  logic               id_rd_i,
   output logic [7:0]         id_o,
   output logic               irq_o
);

   if (N_SRCS != 5)  begin : g_bad_n  $error("uart_int_ident: N_SRCS must be 5");  end
   if (EN_BITS != 4) begin : g_bad_en $error("uart_int_ident: EN_BITS must be 4"); end

   logic [N_SRCS-1:0] en_map, set_v, clr_v, pend, vis, grant;
   logic              any;

   // Timeout shares the received-data enable bit.
   assign en_map = {en_i[3], en_i[2], en_i[1], en_i[1], en_i[0]};
   assign set_v  = src_evt_i & en_map;

   always_comb begin
      clr_v = src_ack_i;
      clr_v[SRC_TXE] = src_ack_i[SRC_TXE] | (id_rd_i & grant[SRC_TXE]);
   end

   uart_iid_pend #(.N(N_SRCS)) u_pend (
      .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr_v), .pend_o(pend)
   );

   assign vis = pend & en_map;

   uart_iid_prio #(.N(N_SRCS)) u_prio (
      .req_i(vis), .grant_o(grant), .any_o(any)
   );

   uart_iid_encode #(.N(N_SRCS), .TOUT_OWN(TOUT_ID)) u_enc (
      .grant_i(grant), .any_i(any), .fifo_en_i(fifo_en_i), .id_o(id_o)
   );

   assign irq_o = ~id_o[0];

   p_idle_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      id_o[0] |-> (id_o[3:1] == 3'b000));

   p_bit3_tout_r4: assert property (@(posedge clk) disable iff (!rst_n)
      id_o[3] |-> grant[SRC_TOUT]);

   p_masked_evt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (src_evt_i[SRC_MDM] && !en_i[3] && !pend[SRC_MDM]) |=> !pend[SRC_MDM]);

   p_txe_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[SRC_TXE] && !grant[SRC_TXE] && !src_ack_i[SRC_TXE]) |=> pend[SRC_TXE]);

endmodule

// File: tb/uart_int_ident_bench.sv
module uart_int_ident_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] evt = '0, ack = '0;
   logic [3:0] en = '0;
   logic       fifo = 1'b0, rd = 1'b0;
   logic [7:0] id;
   logic       irq;

   int n_run = 0, n_fail = 0;

   always #4 clk = ~clk;

   uart_int_ident u_uart_int_ident (
      .clk(clk), .rst_n(rst_n), .src_evt_i(evt), .src_ack_i(ack),
      .en_i(en), .fifo_en_i(fifo), .id_rd_i(rd), .id_o(id), .irq_o(irq)
   );

   function automatic logic [7:0] model(input logic [4:0] p, input logic [3:0] e, input logic f);
      logic [4:0] v;
      logic [3:0] c;
      v = p & {e[3], e[2], e[1], e[1], e[0]};
      if      (v[0]) c = 4'b0110;
      else if (v[1]) c = 4'b0100;
      else if (v[2]) c = 4'b1100;
      else if (v[3]) c = 4'b0010;
      else if (v[4]) c = 4'b0000;
      else           c = 4'b0001;
      return {{2{f}}, 2'b00, c};
   endfunction

   task automatic check(input string req, input logic [7:0] exp);
      n_run++;
      if (id !== exp || irq !== ~exp[0]) begin
         n_fail++;
         $display("FAIL %s: id=%h irq=%b expected id=%h irq=%b", req, id, irq, exp, ~exp[0]);
      end
   endtask

   task automatic step;
      @(negedge clk);
   endtask

   task automatic pulse_evt(input logic [4:0] v);
      evt = v; step(); evt = '0;
   endtask

   task automatic pulse_ack(input logic [4:0] v);
      ack = v; step(); ack = '0;
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      step(); step();
      #1 check("R1 reset", 8'h01);
      rst_n = 1'b1;
      step();

      // R2 R3 R4 R8 R10: sweep pending sets against enable masks and FIFO state
      for (int p = 0; p < 32; p++) begin
         for (int e = 0; e < 16; e++) begin
            for (int f = 0; f < 2; f++) begin
               en = 4'hF; pulse_ack(5'h1F);
               pulse_evt(p[4:0]);
               en = e[3:0]; fifo = f[0];
               #1 check("R3 sweep", model(p[4:0], e[3:0], f[0]));
            end
         end
      end
      fifo = 1'b0;

      // R6 R7: service sequence, one source at a time
      en = 4'hF; pulse_ack(5'h1F);
      pulse_evt(5'h1F);
      check("R3 top line", 8'h06);
      pulse_ack(5'b00001); check("R6 next rxd", 8'h04);
      pulse_ack(5'b00010); check("R4 next timeout", 8'h0C);
      pulse_ack(5'b00100); check("R6 next txe", 8'h02);
      rd = 1'b1; step(); rd = 1'b0;
      check("R7 read clears txe", 8'h00);
      pulse_ack(5'b10000); check("R2 all clear", 8'h01);

      // R7: a read while a higher source is shown leaves txe pending
      pulse_evt(5'b01010);
      rd = 1'b1; step(); rd = 1'b0;
      check("R7 read keeps txe", 8'h04);
      pulse_ack(5'b00010); check("R7 txe still pending", 8'h02);
      pulse_ack(5'b01000); check("R6 txe ack", 8'h01);

      // R5: an event while disabled is never latched
      en = 4'b1011; pulse_evt(5'b01000);
      en = 4'hF; #1 check("R5 disabled event dropped", 8'h01);
      step();
      // R5: masking hides but keeps pending
      pulse_evt(5'b10000);
      en = 4'b0111; #1 check("R5 masked hidden", 8'h01);
      en = 4'hF; #1 check("R5 unmask restores", 8'h00);
      step();

      // R9: event and ack on the same edge
      evt = 5'b10000; ack = 5'b10000; step(); evt = '0; ack = '0;
      check("R9 event wins", 8'h00);
      pulse_ack(5'b10000); check("R9 then cleared", 8'h01);

      // R10: rx enable alone covers timeout
      en = 4'b0010; pulse_evt(5'b00100);
      check("R10 timeout via rx enable", 8'h0C);
      fifo = 1'b1; #1 check("R8 fifo bits", 8'hCC);
      pulse_ack(5'b00100); check("R8 idle with fifo", 8'hC1);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule